// File: doc/BRIEF.md
# Data Memory Address Generator

This block forms the operand address that a small DSP datapath presents to its data memory. Direct instructions get a paged address. A one-bit page pointer sits above a 7-bit offset taken from the instruction word, so each page holds 128 words and two pages cover the 256-word data space. Indirect instructions use the low byte of one of two 16-bit auxiliary registers. A pointer register chooses which of the two is used.

On an indirect access the block can also step the selected auxiliary register up or down by one and switch the pointer to the other register. Both updates happen on the same clock edge that ends the access. Immediate-operand instructions take their data from the instruction word, so the block raises no address for them. Separate load ports write the page pointer, either auxiliary register and the pointer. The address path is combinational from the current register contents, and all register updates take effect at the next rising clock edge.

Top module: `dmem_addr_gen`

## Requirements
- R1: When `opValid` is high and `mode` is 0 (direct), `addrValid` is 1 and `dataAddr` equals `{dpOut, dirOffset}`, with the page pointer in bit 7 and the offset in bits 6:0.
- R2: When `opValid` is high and `mode` is 1 (indirect), `addrValid` is 1 and `dataAddr` equals bits 7:0 of the auxiliary register selected by `arpOut` (0 selects `ar0Out`, 1 selects `ar1Out`).
- R3: When `mode` is 2 or 3 (immediate), or when `opValid` is low, `addrValid` is 0 and `dataAddr` is 0.
- R4: An indirect access with `incReq`=1 and `decReq`=0 adds one to the selected auxiliary register at the next edge, wrapping from 16'hFFFF to 0.
- R5: An indirect access with `decReq`=1 and `incReq`=0 subtracts one from the selected auxiliary register at the next edge, wrapping from 0 to 16'hFFFF.
- R6: An indirect access with both `incReq` and `decReq` high leaves the selected auxiliary register unchanged.
- R7: An indirect access with `arpChgEn`=1 loads `arpNew` into the pointer at the next edge. Any post-modification in the same access acts on the register that the old pointer value selected.
- R8: Outside a valid indirect access, `incReq`, `decReq`, `arpChgEn` and `arpNew` have no effect on the auxiliary registers or the pointer.
- R9: `dpLoadEn`, `arLoadEn` (with `arLoadSel` choosing the register) and `arpLoadEn` write `dpLoadVal`, `arLoadVal` and `arpLoadVal` at the next edge.
- R10: An auxiliary register load takes priority over post-modification of the same register in the same cycle. A pointer load through `arpLoadEn` takes priority over an indirect pointer change.
- R11: While `rst_n` is low, the page pointer, both auxiliary registers and the pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An instruction occupies this cycle |
| mode | input | 2 | 0 direct, 1 indirect, 2/3 immediate |
| dirOffset | input | 7 | Offset field for direct mode |
| incReq | input | 1 | Post-increment request (indirect) |
| decReq | input | 1 | Post-decrement request (indirect) |
| arpChgEn | input | 1 | Change the pointer during an indirect access |
| arpNew | input | 1 | New pointer value for an indirect access |
| dpLoadEn | input | 1 | Page pointer load strobe |
| dpLoadVal | input | 1 | Page pointer load value |
| arLoadEn | input | 1 | Auxiliary register load strobe |
| arLoadSel | input | 1 | Auxiliary register chosen for the load |
| arLoadVal | input | 16 | Auxiliary register load value |
| arpLoadEn | input | 1 | Pointer load strobe |
| arpLoadVal | input | 1 | Pointer load value |
| dataAddr | output | 8 | Data memory address |
| addrValid | output | 1 | Address is meaningful this cycle |
| dpOut | output | 1 | Current page pointer |
| ar0Out | output | 16 | Current auxiliary register 0 |
| ar1Out | output | 16 | Current auxiliary register 1 |
| arpOut | output | 1 | Current auxiliary register pointer |

## Verification
Direct mode is swept over every offset on both pages. A wrong bit order or a dropped page bit therefore shows up as a mismatched address, not as a coincidental match. Indirect mode runs with each pointer value against register contents that differ in their upper byte and at the wrap points 16'h0000, 16'h00FF and 16'hFFFF. These values separate a truncation error from a carry error and an increment from a decrement. Sequences that combine a pointer change with post-modification, loads that coincide with post-modification, and immediate or idle cycles that carry modification requests show whether the old or the new pointer is used and whether ignored requests leak into the registers.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_INDIRECT = 2'd1,
    MODE_IMM_A    = 2'd2,
    MODE_IMM_B    = 2'd3
  } addr_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic isDirect;
    logic isIndirect;
    logic postInc;
    logic postDec;
    logic arpChg;
  } dmag_strobe_t;

endpackage

// File: rtl/dmag_ctrl.sv
module dmag_ctrl
  import dmag_pkg::*;
(
  input  logic         opValid,
  input  logic [1:0]   mode,
  input  logic         incReq,
  input  logic         decReq,
  input  logic         arpChgEn,
  output dmag_strobe_t strobes
);

  logic indAcc;

  always_comb begin
    indAcc             = opValid && (mode == MODE_INDIRECT);
    strobes.isDirect   = opValid && (mode == MODE_DIRECT);
    strobes.isIndirect = indAcc;
    strobes.postInc    = indAcc && incReq && !decReq;
    strobes.postDec    = indAcc && decReq && !incReq;
    strobes.arpChg     = indAcc && arpChgEn;
  end

  // R6
  always_comb begin
    postmod_excl_chk: assert (!(strobes.postInc && strobes.postDec));
  end

endmodule

// File: rtl/dmag_datapath.sv
module dmag_datapath
  import dmag_pkg::*;
#(
  parameter int AR_W   = 16,
  parameter int OFFS_W = 7,
  parameter int ARP_W  = 1,
  localparam int ADDR_W = OFFS_W + 1,
  localparam int NUM_AR = 2 ** ARP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dmag_strobe_t      strobes,
  input  logic [OFFS_W-1:0] dirOffset,
  input  logic [ARP_W-1:0]  arpNew,
  input  logic              dpLoadEn,
  input  logic              dpLoadVal,
  input  logic              arLoadEn,
  input  logic [ARP_W-1:0]  arLoadSel,
  input  logic [AR_W-1:0]   arLoadVal,
  input  logic              arpLoadEn,
  input  logic [ARP_W-1:0]  arpLoadVal,
  output logic [ADDR_W-1:0] dataAddr,
  output logic              addrValid,
  output logic              dpOut,
  output logic [AR_W-1:0]   arOut [NUM_AR],
  output logic [ARP_W-1:0]  arpOut
);

  logic             dpReg;
  logic [ARP_W-1:0] arpReg;
  logic [AR_W-1:0]  arReg [NUM_AR];

  // page pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dpReg <= 1'b0;
    else if (dpLoadEn) dpReg <= dpLoadVal;
  end

  // pointer: load port wins over indirect change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               arpReg <= '0;
    else if (arpLoadEn)       arpReg <= arpLoadVal;
    else if (strobes.arpChg)  arpReg <= arpNew;
  end

  // auxiliary registers, post-modified through the old pointer value
  for (genvar i = 0; i < NUM_AR; i++) begin : g_ar
    logic           hit;
    logic           ldHit;
    logic [AR_W-1:0] q;

    assign hit   = (arpReg == ARP_W'(i));
    assign ldHit = arLoadEn && (arLoadSel == ARP_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q <= '0;
      else if (ldHit)                  q <= arLoadVal;
      else if (strobes.postInc && hit) q <= q + AR_W'(1);
      else if (strobes.postDec && hit) q <= q - AR_W'(1);
    end

    assign arReg[i] = q;
    assign arOut[i] = q;
  end

  // address mux
  always_comb begin
    dataAddr  = '0;
    addrValid = 1'b0;
    if (strobes.isDirect) begin
      dataAddr  = {dpReg, dirOffset};
      addrValid = 1'b1;
    end else if (strobes.isIndirect) begin
      dataAddr  = arReg[arpReg][ADDR_W-1:0];
      addrValid = 1'b1;
    end
  end

  assign dpOut  = dpReg;
  assign arpOut = arpReg;

  // R7
  arp_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.arpChg && !arpLoadEn) |=> (arpReg == $past(arpNew)));

  // R10
  ar_load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arLoadEn && (strobes.postInc || strobes.postDec))
      |=> (arReg[$past(arLoadSel)] == $past(arLoadVal)));

  // R9
  dp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dpLoadEn |=> (dpReg == $past(dpLoadVal)));

endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dmag_pkg::*;
#(
  parameter int AR_W   = 16,
  parameter int OFFS_W = 7,
  localparam int ADDR_W = OFFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [1:0]        mode,
  input  logic [OFFS_W-1:0] dirOffset,
  input  logic              incReq,
  input  logic              decReq,
  input  logic              arpChgEn,
  input  logic              arpNew,
  input  logic              dpLoadEn,
  input  logic              dpLoadVal,
  input  logic              arLoadEn,
  input  logic              arLoadSel,
  input  logic [AR_W-1:0]   arLoadVal,
  input  logic              arpLoadEn,
  input  logic              arpLoadVal,
  output logic [ADDR_W-1:0] dataAddr,
  output logic              addrValid,
  output logic              dpOut,
  output logic [AR_W-1:0]   ar0Out,
  output logic [AR_W-1:0]   ar1Out,
  output logic              arpOut
);

  dmag_strobe_t    strobes;
  logic [AR_W-1:0] arOut [2];

  dmag_ctrl ctrl_i (
    .opValid (opValid),
    .mode    (mode),
    .incReq  (incReq),
    .decReq  (decReq),
    .arpChgEn(arpChgEn),
    .strobes (strobes)
  );

  dmag_datapath #(
    .AR_W  (AR_W),
    .OFFS_W(OFFS_W),
    .ARP_W (1)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .dirOffset (dirOffset),
    .arpNew    (arpNew),
    .dpLoadEn  (dpLoadEn),
    .dpLoadVal (dpLoadVal),
    .arLoadEn  (arLoadEn),
    .arLoadSel (arLoadSel),
    .arLoadVal (arLoadVal),
    .arpLoadEn (arpLoadEn),
    .arpLoadVal(arpLoadVal),
    .dataAddr  (dataAddr),
    .addrValid (addrValid),
    .dpOut     (dpOut),
    .arOut     (arOut),
    .arpOut    (arpOut)
  );

  assign ar0Out = arOut[0];
  assign ar1Out = arOut[1];

  // R3
  no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!opValid || mode[1]) |-> (!addrValid && dataAddr == '0));

  // R1
  direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && mode == 2'd0) |-> (addrValid && dataAddr == {dpOut, dirOffset}));

  // R4
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && mode == 2'd1 && incReq && !decReq && !arLoadEn && !arpOut)
      |=> (ar0Out == $past(ar0Out) + AR_W'(1)));

  // R6
  both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && mode == 2'd1 && incReq && decReq && !arLoadEn)
      |=> ($stable(ar0Out) && $stable(ar1Out)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(opValid && mode == 2'd1) && !arLoadEn && !arpLoadEn)
      |=> ($stable(ar0Out) && $stable(ar1Out) && $stable(arpOut)));

endmodule

// File: tb/dmem_addr_gen_tb.sv
module dmem_addr_gen_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 0;
  logic [1:0]  mode = 0;
  logic [6:0]  dirOffset = 0;
  logic        incReq = 0, decReq = 0, arpChgEn = 0, arpNew = 0;
  logic        dpLoadEn = 0, dpLoadVal = 0;
  logic        arLoadEn = 0, arLoadSel = 0;
  logic [15:0] arLoadVal = 0;
  logic        arpLoadEn = 0, arpLoadVal = 0;
  logic [7:0]  dataAddr;
  logic        addrValid, dpOut, arpOut;
  logic [15:0] ar0Out, ar1Out;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  // bench model
  logic        mDp;
  logic        mArp;
  logic [15:0] mAr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .mode(mode),
    .dirOffset(dirOffset), .incReq(incReq), .decReq(decReq),
    .arpChgEn(arpChgEn), .arpNew(arpNew), .dpLoadEn(dpLoadEn),
    .dpLoadVal(dpLoadVal), .arLoadEn(arLoadEn), .arLoadSel(arLoadSel),
    .arLoadVal(arLoadVal), .arpLoadEn(arpLoadEn), .arpLoadVal(arpLoadVal),
    .dataAddr(dataAddr), .addrValid(addrValid), .dpOut(dpOut),
    .ar0Out(ar0Out), .ar1Out(ar1Out), .arpOut(arpOut)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    opValid = 0; mode = 0; dirOffset = 0; incReq = 0; decReq = 0;
    arpChgEn = 0; arpNew = 0; dpLoadEn = 0; dpLoadVal = 0;
    arLoadEn = 0; arLoadSel = 0; arLoadVal = 0; arpLoadEn = 0; arpLoadVal = 0;
  endtask

  // inputs already set; check address now, clock once, check state
  task automatic step(string req);
    logic        valid;
    logic [7:0]  addr;
    logic [15:0] nAr [2];
    logic        nArp;
    logic        indAcc;
    #1;
    valid  = opValid && (mode < 2);
    addr   = !valid ? 8'h00 : (mode == 0) ? {mDp, dirOffset} : mAr[mArp][7:0];
    check(req, "addrValid", addrValid, valid);
    check(req, "dataAddr", dataAddr, addr);
    indAcc = opValid && mode == 1;
    nAr = mAr;
    nArp = mArp;
    if (indAcc && incReq && !decReq) nAr[mArp] = mAr[mArp] + 16'd1;
    if (indAcc && decReq && !incReq) nAr[mArp] = mAr[mArp] - 16'd1;
    if (arLoadEn) nAr[arLoadSel] = arLoadVal;
    if (indAcc && arpChgEn) nArp = arpNew;
    if (arpLoadEn) nArp = arpLoadVal;
    if (dpLoadEn) mDp = dpLoadVal;
    mAr = nAr;
    mArp = nArp;
    @(posedge clk);
    #1;
    check(req, "dp", dpOut, mDp);
    check(req, "ar0", ar0Out, mAr[0]);
    check(req, "ar1", ar1Out, mAr[1]);
    check(req, "arp", arpOut, mArp);
    clearIn();
  endtask

  task automatic loadAr(logic sel, logic [15:0] v);
    arLoadEn = 1; arLoadSel = sel; arLoadVal = v;
    step("R9");
  endtask

  task automatic setArp(logic v);
    arpLoadEn = 1; arpLoadVal = v;
    step("R9");
  endtask

  task automatic indirect(string req, logic inc, logic dec);
    opValid = 1; mode = 1; incReq = inc; decReq = dec;
    step(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] vals [6];
    vals[0] = 16'h0000; vals[1] = 16'h00FF; vals[2] = 16'hFFFF;
    vals[3] = 16'h1234; vals[4] = 16'hAB80; vals[5] = 16'h7F7F;
    mDp = 0; mArp = 0; mAr[0] = 0; mAr[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11", "dp", dpOut, 0);
    check("R11", "ar0", ar0Out, 0);
    check("R11", "ar1", ar1Out, 0);
    check("R11", "arp", arpOut, 0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;

    // R1 direct sweep over both pages
    for (int p = 0; p < 2; p++) begin
      dpLoadEn = 1; dpLoadVal = p[0];
      step("R9");
      for (int o = 0; o < 128; o++) begin
        opValid = 1; mode = 0; dirOffset = o[6:0];
        incReq = o[0]; decReq = o[1]; arpChgEn = o[2]; arpNew = 1;  // R8
        step("R1");
      end
    end

    // R2 indirect read with both pointers and many values
    for (int k = 0; k < 6; k++) begin
      loadAr(0, vals[k]);
      loadAr(1, ~vals[k] ^ 16'h5A00);
      for (int a = 0; a < 2; a++) begin
        setArp(a[0]);
        indirect("R2", 0, 0);
      end
    end

    // R4 / R5 / R6 post-modification, wrap points, both registers
    for (int a = 0; a < 2; a++) begin
      setArp(a[0]);
      loadAr(a[0], 16'hFFFE);
      indirect("R4", 1, 0);
      indirect("R4", 1, 0);
      indirect("R4", 1, 0);
      loadAr(a[0], 16'h0001);
      indirect("R5", 0, 1);
      indirect("R5", 0, 1);
      indirect("R5", 0, 1);
      loadAr(a[0], 16'h00FF);
      indirect("R4", 1, 0);
      indirect("R6", 1, 1);
      indirect("R6", 1, 1);
      indirect("R5", 0, 1);
    end

    // R7 pointer change with post-modification on old pointer
    loadAr(0, 16'h0010);
    loadAr(1, 16'h0020);
    setArp(0);
    for (int n = 0; n < 8; n++) begin
      opValid = 1; mode = 1; incReq = n[0]; decReq = !n[0];
      arpChgEn = 1; arpNew = !mArp;
      step("R7");
    end
    opValid = 1; mode = 1; incReq = 1; arpChgEn = 0; arpNew = !mArp;
    step("R7");

    // R3 / R8 immediate and idle cycles carrying requests
    for (int m = 2; m < 4; m++) begin
      for (int r = 0; r < 8; r++) begin
        opValid = 1; mode = m[1:0]; dirOffset = 7'h55;
        incReq = r[0]; decReq = r[1]; arpChgEn = r[2]; arpNew = !mArp;
        step("R3");
      end
    end
    for (int m = 0; m < 4; m++) begin
      opValid = 0; mode = m[1:0]; incReq = 1; arpChgEn = 1; arpNew = !mArp;
      step("R8");
    end

    // R10 load priority
    setArp(1);
    loadAr(1, 16'h4000);
    opValid = 1; mode = 1; incReq = 1;
    arLoadEn = 1; arLoadSel = 1; arLoadVal = 16'h0BEE;
    step("R10");
    opValid = 1; mode = 1; decReq = 1;
    arLoadEn = 1; arLoadSel = 0; arLoadVal = 16'h0C00;
    step("R10");
    opValid = 1; mode = 1; arpChgEn = 1; arpNew = 0;
    arpLoadEn = 1; arpLoadVal = 1;
    step("R10");
    opValid = 1; mode = 1; arpChgEn = 1; arpNew = 1;
    arpLoadEn = 1; arpLoadVal = 0;
    step("R10");
    check("R10", "arp final", arpOut, 0);

    // R11 reset in mid-run
    rst_n = 0;
    #1;
    mDp = 0; mArp = 0; mAr[0] = 0; mAr[1] = 0;
    check("R11", "ar0 after reset", ar0Out, 0);
    check("R11", "ar1 after reset", ar1Out, 0);
    check("R11", "arp after reset", arpOut, 0);
    check("R11", "dp after reset", dpOut, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule